// File: doc/BRIEF.md
# Shared-Bus Register Transfer Datapath

This block is the data side of a simple processor core in which every storage element meets on a single internal bus. The block contains eight general registers, a program counter, an instruction register, an operand staging register (Y) and a result staging register (Z). Each register has a load control and, except Y, an output control. An outside control unit sets these controls, together with the ALU operation and the ALU input select, once per clock. Instruction steps are therefore built as sequences of single-bus transfers.

The ALU is combinational. Its A operand is either Y or the constant four, and its B operand is whatever the bus carries. The ALU result can be kept only by loading Z. A later step then places Z on the bus to reach the destination. An extra bus source, `ext_data`, gated by `ext_drive`, lets the surrounding memory logic put words on the bus. The bus value is visible at `bus_out`, so the control unit and the memory side can capture it. If more than one source drives the bus in the same cycle, `bus_conflict` goes high.

Top module: `sbus_datapath`

## Requirements
- R1: A synchronous reset (`rst_n` low at a rising edge) clears all general registers, Y, Z, the PC and the IR to zero.
- R2: When exactly one output control is high, `bus_out` equals that source's contents in the same cycle. Every register whose load control is high takes the `bus_out` value at the next rising edge.
- R3: When no output control is high, `bus_out` is zero and `bus_conflict` is low.
- R4: When two or more output controls are high, `bus_conflict` is high and `bus_out` is zero. Any register loaded in that cycle receives zero.
- R5: The ALU A input is the constant 4 when `sel_four` is 1 and Y when `sel_four` is 0. The B input is the bus.
- R6: The `alu_op` encodings are 000 pass B, 001 A+B, 010 A−B, 011 A AND B, 100 A OR B, 101 A XOR B. The unused codes 110 and 111 pass B. Results wrap modulo 2^32.
- R7: Adding two registers into a third takes three steps. In step 1 the source drives the bus and Y loads. In step 2 the second source drives the bus with add and `z_load` high. In step 3 Z drives the bus and the destination loads.
- R8: With the PC on the bus, `sel_four`=1, add and `z_load`, followed by Z on the bus with `pc_load`, the PC advances by 4. `pc_out` shows the new value one edge after `pc_load`.
- R9: A register whose load control is low keeps its value. In particular, Z ignores the ALU result while `z_load` is low.
- R10: `ir_load` captures the bus into the IR. `ir_out` shows it after the edge, and `ir_drive` puts it back on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| gpr_load | input | 8 | Load controls, one per general register |
| gpr_drive | input | 8 | Output controls, one per general register |
| y_load | input | 1 | Load Y from the bus |
| z_load | input | 1 | Load Z from the ALU result |
| z_drive | input | 1 | Put Z on the bus |
| pc_load | input | 1 | Load the PC from the bus |
| pc_drive | input | 1 | Put the PC on the bus |
| ir_load | input | 1 | Load the IR from the bus |
| ir_drive | input | 1 | Put the IR on the bus |
| ext_drive | input | 1 | Put `ext_data` on the bus |
| ext_data | input | 32 | Word from the memory side |
| sel_four | input | 1 | ALU A select: 1 = constant 4, 0 = Y |
| alu_op | input | 3 | ALU operation code |
| bus_out | output | 32 | Current bus value |
| bus_conflict | output | 1 | More than one bus source enabled |
| pc_out | output | 32 | Program counter contents |
| ir_out | output | 32 | Instruction register contents |

## Verification
Nearly all internal state reaches the ports only when it is driven onto the bus. A corrupted general register, Y or Z therefore stays hidden until a later step reads it. That step may come one edge later or many steps later. For this reason the bench reads every register back after writing it and after each ALU step, and it checks the staged Y value through the Z result. PC and IR faults show on `pc_out` and `ir_out` one edge after the load. Arbitration faults show on `bus_out` and `bus_conflict` in the same cycle.

// File: rtl/sbus_pkg.sv
// Shared types for the single-bus datapath.
// Assumes: the ALU operation code is 3 bits wide.
package sbus_pkg;
    typedef enum logic [2:0] {
        OP_PASS = 3'b000,
        OP_ADD  = 3'b001,
        OP_SUB  = 3'b010,
        OP_AND  = 3'b011,
        OP_OR   = 3'b100,
        OP_XOR  = 3'b101
    } alu_op_e;
endpackage

// File: rtl/sbus_reg.sv
// Gated storage register: takes d at the rising edge when load is high.
// Assumes: synchronous active-low reset that clears to zero.
module sbus_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Hold the value, or replace it on load, or clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/sbus_alu.sv
// Combinational ALU. Unknown op codes pass B through.
// Assumes: there is no internal storage; callers capture the result.
module sbus_alu
    import sbus_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    // Choose the result for the requested operation.
    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            default: y = b;
        endcase
    end
endmodule

// File: rtl/sbus_arbiter.sv
// Bus multiplexer for N gated sources. It yields zero when no source drives
// and flags a conflict (also yielding zero) when several drive.
// Assumes: the enables are level controls valid for the whole cycle.
module sbus_arbiter #(
    parameter int W = 32,
    parameter int N = 12
) (
    input  logic [W-1:0] src [N],
    input  logic [N-1:0] en,
    output logic [W-1:0] bus,
    output logic         conflict
);
    localparam int CW = $clog2(N + 1);

    logic [CW-1:0] n_active;
    logic [W-1:0]  merged;

    // Count the active drivers and merge their gated values.
    always_comb begin
        n_active = '0;
        merged   = '0;
        for (int i = 0; i < N; i++) begin
            if (en[i]) begin
                n_active = n_active + CW'(1);
                merged   = merged | src[i];
            end
        end
    end

    // Drive the bus only when the ownership is unambiguous.
    always_comb begin
        conflict = (n_active > CW'(1));
        bus      = conflict ? '0 : merged;
    end
endmodule

// File: rtl/sbus_datapath.sv
// Single-bus datapath: general registers, Y, Z, PC and IR on one bus.
// The ALU A input is Y or the constant 4, and B is the bus.
// Assumes: an outside sequencer sets all controls at the start of each cycle.
module sbus_datapath
    import sbus_pkg::*;
#(
    parameter int W      = 32,
    parameter int NGPR   = 8,
    parameter int INCR   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NGPR-1:0] gpr_load,
    input  logic [NGPR-1:0] gpr_drive,
    input  logic            y_load,
    input  logic            z_load,
    input  logic            z_drive,
    input  logic            pc_load,
    input  logic            pc_drive,
    input  logic            ir_load,
    input  logic            ir_drive,
    input  logic            ext_drive,
    input  logic [W-1:0]    ext_data,
    input  logic            sel_four,
    input  logic [2:0]      alu_op,
    output logic [W-1:0]    bus_out,
    output logic            bus_conflict,
    output logic [W-1:0]    pc_out,
    output logic [W-1:0]    ir_out
);
    localparam int IDX_Z   = NGPR;
    localparam int IDX_PC  = NGPR + 1;
    localparam int IDX_IR  = NGPR + 2;
    localparam int IDX_EXT = NGPR + 3;
    localparam int NSRC    = NGPR + 4;

    logic [W-1:0]    srcs [NSRC];
    logic [NSRC-1:0] drv;
    logic [W-1:0]    bus;
    logic [W-1:0]    y_q, z_q, pc_q, ir_q;
    logic [W-1:0]    alu_a, alu_y;

    // General register bank, one gated register per entry.
    for (genvar g = 0; g < NGPR; g++) begin : g_gpr
        logic [W-1:0] q;
        sbus_reg #(.W(W)) u_r (
            .clk(clk), .rst_n(rst_n), .load(gpr_load[g]), .d(bus), .q(q)
        );
        assign srcs[g] = q;
    end

    sbus_reg #(.W(W)) u_y  (.clk(clk), .rst_n(rst_n), .load(y_load),  .d(bus),   .q(y_q));
    sbus_reg #(.W(W)) u_z  (.clk(clk), .rst_n(rst_n), .load(z_load),  .d(alu_y), .q(z_q));
    sbus_reg #(.W(W)) u_pc (.clk(clk), .rst_n(rst_n), .load(pc_load), .d(bus),   .q(pc_q));
    sbus_reg #(.W(W)) u_ir (.clk(clk), .rst_n(rst_n), .load(ir_load), .d(bus),   .q(ir_q));

    assign srcs[IDX_Z]   = z_q;
    assign srcs[IDX_PC]  = pc_q;
    assign srcs[IDX_IR]  = ir_q;
    assign srcs[IDX_EXT] = ext_data;
    assign drv = {ext_drive, ir_drive, pc_drive, z_drive, gpr_drive};

    sbus_arbiter #(.W(W), .N(NSRC)) u_arb (
        .src(srcs), .en(drv), .bus(bus), .conflict(bus_conflict)
    );

    // ALU A-side multiplexer: constant increment or staged operand.
    always_comb alu_a = sel_four ? W'(INCR) : y_q;

    sbus_alu #(.W(W)) u_alu (
        .op(alu_op_e'(alu_op)), .a(alu_a), .b(bus), .y(alu_y)
    );

    assign bus_out = bus;
    assign pc_out  = pc_q;
    assign ir_out  = ir_q;
endmodule

// File: rtl/sbus_datapath_chk.sv
// Property checker for sbus_datapath, attached by bind.
// Assumes: it sees the top ports and the internal Z register value.
module sbus_datapath_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         pc_load,
    input logic         ir_load,
    input logic         z_load,
    input logic         sel_four,
    input logic [2:0]   alu_op,
    input logic [W-1:0] bus_out,
    input logic         bus_conflict,
    input logic [W-1:0] pc_out,
    input logic [W-1:0] ir_out,
    input logic [W-1:0] z_value
);
    // R4
    conflict_zero_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_conflict |-> (bus_out == '0));
    // R2
    pc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && pc_load) |=> (pc_out == $past(bus_out)));
    // R10
    ir_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && ir_load) |=> (ir_out == $past(bus_out)));
    // R9
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !pc_load) |=> $stable(pc_out));
    // R9
    z_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !z_load) |=> $stable(z_value));
    // R8
    z_increment_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && z_load && sel_four && alu_op == 3'b001)
        |=> (z_value == $past(bus_out) + W'(4)));
endmodule

bind sbus_datapath sbus_datapath_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pc_load(pc_load), .ir_load(ir_load),
    .z_load(z_load), .sel_four(sel_four), .alu_op(alu_op),
    .bus_out(bus_out), .bus_conflict(bus_conflict), .pc_out(pc_out),
    .ir_out(ir_out), .z_value(z_q)
);

// File: tb/sim_sbus_datapath.sv
`timescale 1ns/1ps
// Scoreboard bench: steps push expected observations and a monitor compares them.
module sim_sbus_datapath;
    localparam int W = 32;

    typedef struct {
        int          kind;   // 0 bus, 1 conflict, 2 pc, 3 ir
        logic [W-1:0] value;
        string       req;
    } exp_t;

    logic         clk = 0, rst_n = 0;
    logic [7:0]   gpr_load, gpr_drive;
    logic         y_load, z_load, z_drive, pc_load, pc_drive;
    logic         ir_load, ir_drive, ext_drive, sel_four;
    logic [W-1:0] ext_data;
    logic [2:0]   alu_op;
    logic [W-1:0] bus_out, pc_out, ir_out;
    logic         bus_conflict;

    exp_t q[$];
    int   n_checks = 0, n_errors = 0;
    bit   done = 0;

    always #2.5 clk = ~clk;

    sbus_datapath u0 (
        .clk(clk), .rst_n(rst_n), .gpr_load(gpr_load), .gpr_drive(gpr_drive),
        .y_load(y_load), .z_load(z_load), .z_drive(z_drive), .pc_load(pc_load),
        .pc_drive(pc_drive), .ir_load(ir_load), .ir_drive(ir_drive),
        .ext_drive(ext_drive), .ext_data(ext_data), .sel_four(sel_four),
        .alu_op(alu_op), .bus_out(bus_out), .bus_conflict(bus_conflict),
        .pc_out(pc_out), .ir_out(ir_out)
    );

    // Start a new control step with every control low.
    task automatic step();
        @(negedge clk);
        gpr_load = '0; gpr_drive = '0; y_load = 0; z_load = 0; z_drive = 0;
        pc_load = 0; pc_drive = 0; ir_load = 0; ir_drive = 0; ext_drive = 0;
        sel_four = 0; alu_op = 3'b000; ext_data = '0;
    endtask

    task automatic expect_val(int kind, logic [W-1:0] v, string req);
        exp_t e;
        e.kind = kind; e.value = v; e.req = req;
        q.push_back(e);
    endtask

    // Write a word into general register r through the external source.
    task automatic write_gpr(int r, logic [W-1:0] v);
        step(); ext_data = v; ext_drive = 1; gpr_load[r] = 1;
        expect_val(0, v, "R2");
    endtask

    // Reference ALU from the R6 encodings.
    function automatic logic [W-1:0] ref_alu(logic [2:0] op, logic [W-1:0] a, logic [W-1:0] b);
        case (op)
            3'b001: return a + b;
            3'b010: return a - b;
            3'b011: return a & b;
            3'b100: return a | b;
            3'b101: return a ^ b;
            default: return b;
        endcase
    endfunction

    // Monitor: compare queued expectations mid-low-phase of the clock.
    always @(negedge clk) begin
        #1;
        while (q.size() > 0) begin
            exp_t e;
            logic [W-1:0] act;
            e = q.pop_front();
            case (e.kind)
                0: act = bus_out;
                1: act = {{(W-1){1'b0}}, bus_conflict};
                2: act = pc_out;
                default: act = ir_out;
            endcase
            n_checks++;
            if (act !== e.value) begin
                n_errors++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", e.req, e.kind, act, e.value);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #200000;
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        logic [W-1:0] a4, b5;
        a4 = 32'hF0F0_00FF; b5 = 32'h0FF0_0F0F;
        step(); rst_n = 0;
        step(); step();
        step(); rst_n = 1;
        // R1: every register reads zero after reset
        for (int r = 0; r < 8; r++) begin
            step(); gpr_drive[r] = 1; expect_val(0, '0, "R1");
        end
        step(); z_drive = 1; expect_val(0, '0, "R1");
        expect_val(2, '0, "R1"); expect_val(3, '0, "R1");
        // R3: idle bus
        step(); expect_val(0, '0, "R3"); expect_val(1, '0, "R3");
        write_gpr(1, 32'h1111_1111);
        write_gpr(2, 32'h2222_2222);
        write_gpr(4, a4);
        write_gpr(5, b5);
        // R2: read back a register
        step(); gpr_drive[1] = 1; expect_val(0, 32'h1111_1111, "R2");
        expect_val(1, '0, "R2");
        // R7: three-step add R1 + R2 -> R3
        step(); gpr_drive[1] = 1; y_load = 1;
        step(); gpr_drive[2] = 1; alu_op = 3'b001; z_load = 1;
        expect_val(0, 32'h2222_2222, "R7");
        step(); z_drive = 1; gpr_load[3] = 1; expect_val(0, 32'h3333_3333, "R7");
        step(); gpr_drive[3] = 1; expect_val(0, 32'h3333_3333, "R7");
        // R6: every op code with Y = R4 and B = R5
        step(); gpr_drive[4] = 1; y_load = 1;
        for (int op = 0; op < 8; op++) begin
            step(); gpr_drive[5] = 1; alu_op = 3'(op); z_load = 1;
            step(); z_drive = 1; expect_val(0, ref_alu(3'(op), a4, b5), "R6");
        end
        // R9: Z ignores the ALU while z_load is low
        step(); gpr_drive[1] = 1; alu_op = 3'b001;
        step(); z_drive = 1; expect_val(0, ref_alu(3'b111, a4, b5), "R9");
        // R5: Y selected vs constant 4 on the A input
        step(); gpr_drive[2] = 1; alu_op = 3'b001; sel_four = 1; z_load = 1;
        step(); z_drive = 1; expect_val(0, 32'h2222_2226, "R5");
        step(); gpr_drive[2] = 1; alu_op = 3'b001; z_load = 1;
        step(); z_drive = 1; expect_val(0, a4 + 32'h2222_2222, "R5");
        // R8: increment the PC twice
        for (int k = 1; k <= 2; k++) begin
            step(); pc_drive = 1; sel_four = 1; alu_op = 3'b001; z_load = 1;
            step(); z_drive = 1; pc_load = 1; expect_val(0, 32'(4 * k), "R8");
            step(); expect_val(2, 32'(4 * k), "R8");
        end
        // R6: subtraction wraps
        step(); pc_drive = 1; y_load = 1;
        step(); gpr_drive[4] = 1; alu_op = 3'b010; z_load = 1;
        step(); z_drive = 1; expect_val(0, 32'd8 - a4, "R6");
        // R10: instruction register capture and drive
        step(); ext_data = 32'hA5A5_5A5A; ext_drive = 1; ir_load = 1;
        step(); expect_val(3, 32'hA5A5_5A5A, "R10");
        step(); ir_drive = 1; expect_val(0, 32'hA5A5_5A5A, "R10");
        // R4: two drivers -> conflict, zero bus, loaded register gets zero
        write_gpr(6, 32'hDEAD_BEEF);
        step(); gpr_drive[1] = 1; gpr_drive[2] = 1; gpr_load[6] = 1;
        expect_val(0, '0, "R4"); expect_val(1, 1, "R4");
        step(); gpr_drive[6] = 1; expect_val(0, '0, "R4");
        expect_val(1, '0, "R4");
        // R9: untouched register keeps its value; PC held
        step(); gpr_drive[2] = 1; expect_val(0, 32'h2222_2222, "R9");
        expect_val(2, 32'd8, "R9");
        // R1: reset in mid-run clears state again
        step(); rst_n = 0;
        step(); rst_n = 1;
        step(); gpr_drive[1] = 1; expect_val(0, '0, "R1");
        expect_val(2, '0, "R1"); expect_val(3, '0, "R1");
        step(); step();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule